// File: doc/BRIEF.md
# Branch Trace Recorder

This block records program-flow discontinuities into a private SRAM with no processor involvement. A trace source presents one branch event at a time: the halfword-aligned source address, the destination address and a flag for sequential flow. Each non-sequential event that is accepted while recording is enabled becomes a two-word record. The block writes the record through its own SRAM port, source word first and destination word second. A record slot is one record index, which is 8 bytes of memory.

The SRAM port is shared with an ordinary bus-side port. Trace writes always win. A bus access that collides with a trace write is held off with a wait signal and is granted in the first cycle with no trace write. When the write pointer passes the last slot, recording wraps to slot 0 and overwrites the oldest records. A wrap flag is set, and bit 0 of the next source word marks the record as the first one after the wrap. When watermark mode is on and the pointer reaches the programmed slot, the block pulses a debug request for one cycle and stops recording until software enables it again. The security register gives each half of the buffer its own secure attribute, which is driven on every SRAM access. Trace writes are never checked against that attribute.

The trace input is a valid/ready stream. An event transfers on a rising edge where both `ev_valid` and `ev_ready` are high. `ev_ready` is high only while no record is being written. It therefore drops for the two cycles in which the record's words are written. While `ev_ready` is low, the source must hold the event and its fields stable. Sequential events and events that arrive while recording is disabled are accepted and discarded.

Top module: `btrace_recorder`

## Requirements
- R1: An accepted event with `ev_seq`=0 while enabled produces two SRAM writes in the next two cycles. The first goes to word address 2p with data {ev_src, flag}. The second goes to 2p+1 with `ev_dst`. Here p is the current slot, and flag is 1 only for the first record after a wrap. p then advances by one.
- R2: An accepted event with `ev_seq`=1 produces no SRAM write and leaves the slot unchanged.
- R3: While the enable bit is 0, accepted events produce no SRAM write and leave the slot unchanged.
- R4: `ev_ready` is 1 out of reset and whenever no record is in progress. It is 0 in the two cycles after a non-sequential event is accepted while enabled.
- R5: A record written in the last slot (REC_DEPTH-1) moves the pointer to slot 0 and sets the wrap flag. Bit 0 of the next record's source word is then 1. It is 0 for every other record.
- R6: With watermark mode on, a record that moves the pointer to the watermark slot causes `dbg_req` to be 1 for exactly the cycle after its second word. The enable bit clears at the same time, and the watermark mode bit is kept.
- R7: A bus access requested in a cycle that has a trace write gets `bus_wait`=1 and does not reach the SRAM. In a cycle with no trace write it is granted with `bus_wait`=0, and `mem_we` follows `bus_we`.
- R8: A granted bus read returns `bus_rvalid`=1 one cycle later, with `bus_rdata` carrying that word's SRAM contents.
- R9: `mem_secure` equals security bit 0 for word addresses in the lower half of the buffer and security bit 1 for the upper half. This holds for trace and bus accesses alike. Trace writes proceed whatever the attribute.
- R10: Of the security register, only bits 1:0 are writable. Reads return 0 in all other bits.
- R11: The configuration registers are selected by `cfg_sel`. Selector 0 is the position register: bit 0 is the wrap flag and bits RW:1 are the slot, where RW = log2(REC_DEPTH). Selector 1 is control: bit 0 enables recording and bit 1 enables watermark mode. Selector 2 is the watermark slot in bits RW-1:0. Selector 3 is security. A write to the position register loads the slot and clears the wrap flag and the first-after-wrap marker. All reads return 0 in unlisted bits, and writes take effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Branch event valid |
| ev_ready | output | 1 | Recorder can take an event |
| ev_seq | input | 1 | Event is sequential flow (discarded) |
| ev_src | input | DW-1 | Branch source address bits DW-1:1 |
| ev_dst | input | DW | Branch destination address |
| bus_req | input | 1 | Bus-side SRAM access request |
| bus_we | input | 1 | Bus access is a write |
| bus_addr | input | RW+1 | Bus word address |
| bus_wdata | input | DW | Bus write data |
| bus_wait | output | 1 | Bus access held off this cycle |
| bus_rvalid | output | 1 | Bus read data valid |
| bus_rdata | output | DW | Bus read data |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | RW+1 | SRAM word address |
| mem_wdata | output | DW | SRAM write data |
| mem_secure | output | 1 | Secure attribute of the addressed half |
| mem_rdata | input | DW | SRAM read data, one cycle after a read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | RW+1 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_sel` |
| dbg_req | output | 1 | One-cycle external debug request |

## Verification
The SRAM port outputs, `bus_wait` and `ev_ready` are combinational on the current phase and inputs, so they are due in the same cycle. The source word is due in the first cycle after the accepting edge and the destination word in the second. The slot, wrap flag, enable clear and `dbg_req` pulse are due one cycle after the destination word. `bus_rvalid` follows a grant by one cycle. Configuration writes are visible on `cfg_rdata` from the next cycle. The bench drives inputs just after each rising edge and updates its queue-based model on the edge. At every falling edge it compares each of these outputs with the model, which holds the cycle offsets above.

// File: rtl/btr_pkg.sv
package btr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SRC  = 2'd1,
    PH_DST  = 2'd2
  } phase_t;

  localparam logic [1:0] SEL_POS   = 2'd0;
  localparam logic [1:0] SEL_CTRL  = 2'd1;
  localparam logic [1:0] SEL_WMARK = 2'd2;
  localparam logic [1:0] SEL_SEC   = 2'd3;
endpackage

// File: rtl/btr_regs.sv
module btr_regs
  import btr_pkg::*;
#(
  parameter int REC_DEPTH = 16,
  parameter int SEC_BITS  = 2,
  localparam int RW = $clog2(REC_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [RW:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  input  logic                rec_done,
  output logic [RW-1:0]       ptr,
  output logic                first_flag,
  output logic                rec_en,
  output logic [SEC_BITS-1:0] sec,
  output logic                dbg_req
);
  logic [RW-1:0]       ptr_q, wm_q, ptr_inc;
  logic                wrap_q, first_q, en_q, wmen_q, dbg_q, at_last, wm_hit;
  logic [SEC_BITS-1:0] sec_q;

  assign at_last = (ptr_q == RW'(REC_DEPTH - 1));
  assign ptr_inc = at_last ? '0 : ptr_q + RW'(1);
  assign wm_hit  = rec_done & wmen_q & (ptr_inc == wm_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      wm_q    <= '0;
      wrap_q  <= 1'b0;
      first_q <= 1'b0;
      en_q    <= 1'b0;
      wmen_q  <= 1'b0;
      dbg_q   <= 1'b0;
      sec_q   <= '0;
    end else begin
      dbg_q <= wm_hit;
      if (rec_done) begin
        ptr_q   <= ptr_inc;
        first_q <= at_last;
        if (at_last) wrap_q <= 1'b1;
        if (wm_hit)  en_q   <= 1'b0;
      end
      if (cfg_we) begin
        case (cfg_sel)
          SEL_POS: begin
            ptr_q   <= cfg_wdata[RW:1];
            wrap_q  <= 1'b0;
            first_q <= 1'b0;
          end
          SEL_CTRL: begin
            en_q   <= cfg_wdata[0];
            wmen_q <= cfg_wdata[1];
          end
          SEL_WMARK: wm_q  <= cfg_wdata[RW-1:0];
          SEL_SEC:   sec_q <= cfg_wdata[SEC_BITS-1:0];
        endcase
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_POS: begin
        cfg_rdata[RW:1] = ptr_q;
        cfg_rdata[0]    = wrap_q;
      end
      SEL_CTRL: begin
        cfg_rdata[0] = en_q;
        cfg_rdata[1] = wmen_q;
      end
      SEL_WMARK: cfg_rdata[RW-1:0]       = wm_q;
      SEL_SEC:   cfg_rdata[SEC_BITS-1:0] = sec_q;
    endcase
  end

  assign ptr        = ptr_q;
  assign first_flag = first_q;
  assign rec_en     = en_q;
  assign sec        = sec_q;
  assign dbg_req    = dbg_q;

  assert_dbg_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_q |=> !dbg_q);
  assert_stop_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_q && !$past(cfg_we && cfg_sel == SEL_CTRL)) |-> !en_q);
  assert_wrap_to_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_done && at_last && !cfg_we) |=> (ptr_q == '0 && wrap_q && first_q));
  assert_sec_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == SEL_SEC) |-> (cfg_rdata[31:SEC_BITS] == '0));
endmodule

// File: rtl/btr_writer.sv
module btr_writer
  import btr_pkg::*;
#(
  parameter int REC_DEPTH = 16,
  parameter int DW        = 32,
  localparam int RW = $clog2(REC_DEPTH),
  localparam int AW = RW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic          ev_seq,
  input  logic [DW-1:1] ev_src,
  input  logic [DW-1:0] ev_dst,
  output logic          ev_ready,
  input  logic          rec_en,
  input  logic [RW-1:0] ptr,
  input  logic          first_flag,
  output logic          tr_busy,
  output logic [AW-1:0] tr_addr,
  output logic [DW-1:0] tr_data,
  output logic          rec_done
);
  phase_t        ph_q;
  logic [DW-1:1] src_q;
  logic [DW-1:0] dst_q;
  logic          take;

  assign ev_ready = (ph_q == PH_IDLE);
  assign take     = ev_valid & ev_ready & rec_en & ~ev_seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      src_q <= '0;
      dst_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (take) begin
          ph_q  <= PH_SRC;
          src_q <= ev_src;
          dst_q <= ev_dst;
        end
        PH_SRC:  ph_q <= PH_DST;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign tr_busy  = (ph_q != PH_IDLE);
  assign rec_done = (ph_q == PH_DST);
  assign tr_addr  = {ptr, rec_done};
  assign tr_data  = rec_done ? dst_q : {src_q, first_flag};

  assert_two_words_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SRC) |=> (rec_done && tr_addr[0] && !$past(tr_addr[0])));
  assert_busy_after_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && rec_en && !ev_seq) |=> !ev_ready);
  assert_seq_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_ready && ev_seq) |=> !tr_busy);
endmodule

// File: rtl/btr_arbiter.sv
module btr_arbiter #(
  parameter int AW       = 5,
  parameter int DW       = 32,
  parameter int SEC_BITS = 2,
  localparam int SEL_W = $clog2(SEC_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tr_busy,
  input  logic [AW-1:0]       tr_addr,
  input  logic [DW-1:0]       tr_data,
  input  logic                bus_req,
  input  logic                bus_we,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic                bus_wait,
  output logic                bus_rvalid,
  output logic [DW-1:0]       bus_rdata,
  input  logic [SEC_BITS-1:0] sec,
  output logic                mem_en,
  output logic                mem_we,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_wdata,
  output logic                mem_secure,
  input  logic [DW-1:0]       mem_rdata
);
  logic bus_grant, rv_q;

  assign bus_grant = bus_req & ~tr_busy;
  assign bus_wait  = bus_req & tr_busy;

  always_comb begin
    mem_en    = tr_busy | bus_req;
    mem_we    = tr_busy | bus_we;
    mem_addr  = tr_busy ? tr_addr : bus_addr;
    mem_wdata = tr_busy ? tr_data : bus_wdata;
  end

  assign mem_secure = sec[mem_addr[AW-1 -: SEL_W]];

  always_ff @(posedge clk) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= bus_grant & ~bus_we;
  end

  assign bus_rvalid = rv_q;
  assign bus_rdata  = mem_rdata;

  assert_trace_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && tr_busy) |-> (bus_wait && mem_we && mem_addr == tr_addr));
  assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wait && !bus_we) |=> bus_rvalid);
endmodule

// File: rtl/btrace_recorder.sv
module btrace_recorder #(
  parameter int REC_DEPTH = 16,
  parameter int DW        = 32,
  parameter int SEC_BITS  = 2,
  localparam int RW = $clog2(REC_DEPTH),
  localparam int AW = RW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  output logic          ev_ready,
  input  logic          ev_seq,
  input  logic [DW-1:1] ev_src,
  input  logic [DW-1:0] ev_dst,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_wait,
  output logic          bus_rvalid,
  output logic [DW-1:0] bus_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_secure,
  input  logic [DW-1:0] mem_rdata,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW:0]   cfg_wdata,
  output logic [31:0]   cfg_rdata,
  output logic          dbg_req
);
  logic [RW-1:0]       ptr;
  logic                first_flag, rec_en, tr_busy, rec_done;
  logic [SEC_BITS-1:0] sec;
  logic [AW-1:0]       tr_addr;
  logic [DW-1:0]       tr_data;

  btr_regs #(.REC_DEPTH(REC_DEPTH), .SEC_BITS(SEC_BITS)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rec_done(rec_done),
    .ptr(ptr), .first_flag(first_flag), .rec_en(rec_en), .sec(sec),
    .dbg_req(dbg_req)
  );

  btr_writer #(.REC_DEPTH(REC_DEPTH), .DW(DW)) u_writer (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_seq(ev_seq),
    .ev_src(ev_src), .ev_dst(ev_dst), .ev_ready(ev_ready), .rec_en(rec_en),
    .ptr(ptr), .first_flag(first_flag), .tr_busy(tr_busy),
    .tr_addr(tr_addr), .tr_data(tr_data), .rec_done(rec_done)
  );

  btr_arbiter #(.AW(AW), .DW(DW), .SEC_BITS(SEC_BITS)) u_arb (
    .clk(clk), .rst_n(rst_n), .tr_busy(tr_busy), .tr_addr(tr_addr),
    .tr_data(tr_data), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wait(bus_wait),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .sec(sec),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_secure(mem_secure), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/tb_btrace_recorder.sv
`timescale 1ns/1ps
module tb_btrace_recorder;
  localparam int DEPTH = 16;
  localparam int RW = 4;
  localparam int AW = RW + 1;
  localparam int NW = 2 * DEPTH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ev_valid = 0, ev_seq = 0;
  logic [31:1] ev_src = '0;
  logic [31:0] ev_dst = '0;
  logic bus_req = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic [RW:0] cfg_wdata = '0;
  logic ev_ready, bus_wait, bus_rvalid, mem_en, mem_we, mem_secure, dbg_req;
  logic [31:0] bus_rdata, mem_wdata, cfg_rdata;
  logic [31:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  btrace_recorder dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_seq(ev_seq), .ev_src(ev_src), .ev_dst(ev_dst), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wait(bus_wait), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_secure(mem_secure), .mem_rdata(mem_rdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .dbg_req(dbg_req)
  );

  // SRAM attached to the block
  logic [31:0] sram [NW];
  initial for (int i = 0; i < NW; i++) sram[i] = '0;
  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) sram[mem_addr] <= mem_wdata;
      else        mem_rdata <= sram[mem_addr];
    end

  int nchk = 0, nerr = 0, ndbg = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: pending record words, slot and flags as plain integers
  int qk[$];
  logic [31:1] qs[$];
  logic [31:0] qd[$];
  logic [31:0] exp_mem [NW];
  int m_ptr, m_wm;
  bit m_wrap, m_first, m_en, m_wmen, m_dbg, m_rv;
  logic [1:0] m_sec;
  logic [31:0] m_rd;
  initial for (int i = 0; i < NW; i++) exp_mem[i] = '0;

  function automatic int head_addr();
    return 2 * m_ptr + qk[0];
  endfunction
  function automatic logic [31:0] head_data();
    return (qk[0] == 1) ? qd[0] : {qs[0], m_first};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      qk.delete(); qs.delete(); qd.delete();
      m_ptr = 0; m_wm = 0; m_wrap = 0; m_first = 0; m_en = 0; m_wmen = 0;
      m_dbg = 0; m_rv = 0; m_sec = '0; m_rd = '0;
    end else begin
      bit acc, dbg_n, rv_n;
      logic [31:0] rd_n;
      dbg_n = 0; rv_n = 0; rd_n = m_rd;
      acc = ev_valid && (qk.size() == 0) && m_en && !ev_seq;
      if (qk.size() != 0) begin
        exp_mem[head_addr()] = head_data();
        if (qk[0] == 1) begin
          if (m_ptr == DEPTH - 1) begin m_ptr = 0; m_wrap = 1; m_first = 1; end
          else begin m_ptr++; m_first = 0; end
          if (m_wmen && m_ptr == m_wm) begin dbg_n = 1; m_en = 0; end
        end
        void'(qk.pop_front()); void'(qs.pop_front()); void'(qd.pop_front());
      end else if (bus_req) begin
        if (bus_we) exp_mem[bus_addr] = bus_wdata;
        else begin rv_n = 1; rd_n = exp_mem[bus_addr]; end
      end
      if (acc) begin
        qk.push_back(0); qs.push_back(ev_src); qd.push_back(ev_dst);
        qk.push_back(1); qs.push_back(ev_src); qd.push_back(ev_dst);
      end
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin m_ptr = int'(cfg_wdata[RW:1]); m_wrap = 0; m_first = 0; end
          2'd1: begin m_en = cfg_wdata[0]; m_wmen = cfg_wdata[1]; end
          2'd2: m_wm = int'(cfg_wdata[RW-1:0]);
          default: m_sec = cfg_wdata[1:0];
        endcase
      end
      m_dbg = dbg_n; m_rv = rv_n; m_rd = rd_n;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] er;
      int ea;
      if (dbg_req) ndbg++;
      chk("R4 ev_ready", ev_ready, qk.size() == 0);
      if (qk.size() != 0) begin
        ea = head_addr();
        chk("R1 mem_en", mem_en, 1);
        chk("R7 mem_we trace", mem_we, 1);
        chk("R1 mem_addr", mem_addr, ea);
        chk((qk[0] == 0 && m_first) ? "R5 src word" : "R1 data word", mem_wdata, head_data());
        chk("R7 bus_wait", bus_wait, bus_req);
        chk("R9 mem_secure", mem_secure, m_sec[ea >> RW]);
      end else if (bus_req) begin
        chk("R7 mem_en bus", mem_en, 1);
        chk("R7 mem_we bus", mem_we, bus_we);
        chk("R7 mem_addr bus", mem_addr, bus_addr);
        chk("R7 bus_wait idle", bus_wait, 0);
        if (bus_we) chk("R7 mem_wdata bus", mem_wdata, bus_wdata);
        chk("R9 mem_secure bus", mem_secure, m_sec[bus_addr >> RW]);
      end else begin
        chk("R2 R3 mem_en idle", mem_en, 0);
      end
      chk("R8 bus_rvalid", bus_rvalid, m_rv);
      if (m_rv) chk("R8 bus_rdata", bus_rdata, m_rd);
      chk("R6 dbg_req", dbg_req, m_dbg);
      case (cfg_sel)
        2'd0: er = 32'((m_ptr << 1) | int'(m_wrap));
        2'd1: er = {30'd0, m_wmen, m_en};
        2'd2: er = 32'(m_wm);
        default: er = {30'd0, m_sec};
      endcase
      chk(cfg_sel == 2'd3 ? "R10 cfg_rdata" : "R11 cfg_rdata", cfg_rdata, er);
    end
  end

  // Stimulus helpers: inputs change 1 ns after a rising edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [RW:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    step(1);
    cfg_we = 0; cfg_sel = 2'd0;
  endtask

  task automatic cfg_expect(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    cfg_sel = sel;
    @(negedge clk);
    chk(tag, cfg_rdata, exp);
    step(1);
    cfg_sel = 2'd0;
  endtask

  task automatic send(input bit seq, input logic [31:1] s, input logic [31:0] d);
    bit ok;
    ev_valid = 1; ev_seq = seq; ev_src = s; ev_dst = d;
    forever begin
      @(negedge clk);
      ok = ev_ready;
      step(1);
      if (ok) break;
    end
    ev_valid = 0; ev_seq = 0;
    step(3);
  endtask

  task automatic bus_drive(input bit we, input logic [AW-1:0] a, input logic [31:0] d, input int n);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    step(n);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d);
    bit g;
    bus_req = 1; bus_we = 0; bus_addr = a;
    forever begin
      @(negedge clk);
      g = !bus_wait;
      step(1);
      if (g) break;
    end
    bus_req = 0;
    @(negedge clk);
    d = bus_rdata;
    step(1);
  endtask

  initial begin
    logic [31:0] rd;
    step(4);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset ready", ev_ready, 1);
    chk("R6 reset dbg", dbg_req, 0);
    step(1);
    cfg_expect(2'd0, 32'd0, "R11 reset position");

    cfg_write(2'd1, 5'd1);
    send(0, 31'h5000_0008, 32'hB000_0020);
    cfg_expect(2'd0, 32'd2, "R1 slot advanced");
    bus_read(5'd0, rd);
    chk("R1 source word", rd, 32'hA000_0010);
    bus_read(5'd1, rd);
    chk("R1 destination word", rd, 32'hB000_0020);

    send(1, 31'h1234_5678, 32'h0000_1000);
    cfg_expect(2'd0, 32'd2, "R2 sequential ignored");

    fork
      send(0, 31'h0000_0111, 32'h0000_0222);
      bus_drive(0, 5'd0, 32'd0, 4);
    join

    cfg_write(2'd1, 5'd0);
    send(0, 31'h0BAD_0001, 32'h0BAD_0002);
    cfg_expect(2'd0, 32'd4, "R3 disabled ignored");
    bus_read(5'd4, rd);
    chk("R3 slot untouched", rd, 32'd0);

    cfg_write(2'd1, 5'd1);
    for (int i = 0; i < DEPTH; i++)
      send(0, 31'(32'h100 + i), 32'h2000_0000 + i);
    cfg_expect(2'd0, 32'd5, "R5 wrap flag set");
    bus_read(5'd0, rd);
    chk("R5 first after wrap marked", rd[0], 1'b1);
    bus_read(5'd2, rd);
    chk("R5 later record unmarked", rd[0], 1'b0);

    cfg_write(2'd0, 5'd20);
    cfg_expect(2'd0, 32'd20, "R11 position write clears wrap");
    cfg_write(2'd3, 5'h1F);
    cfg_expect(2'd3, 32'd3, "R10 security two bits");
    cfg_write(2'd3, 5'h1E);
    cfg_expect(2'd3, 32'd2, "R10 security readback");
    send(0, 31'h0CC0_0001, 32'h0DD0_0002);
    bus_drive(1, 5'd3, 32'h1111_2222, 1);
    bus_drive(1, 5'd30, 32'h3333_4444, 1);
    bus_read(5'd30, rd);
    chk("R8 bus write readback", rd, 32'h3333_4444);

    cfg_write(2'd0, 5'd6);
    cfg_write(2'd2, 5'd5);
    cfg_write(2'd1, 5'd3);
    send(0, 31'h0E00_0001, 32'h0F00_0001);
    send(0, 31'h0E00_0002, 32'h0F00_0002);
    send(0, 31'h0E00_0003, 32'h0F00_0003);
    cfg_expect(2'd1, 32'd2, "R6 enable cleared on hit");
    cfg_expect(2'd0, 32'd10, "R6 recording stopped at watermark");
    chk("R6 single debug pulse", ndbg, 1);

    cfg_write(2'd1, 5'd1);
    for (int i = 0; i < 300; i++) begin
      ev_valid = ($urandom % 3) == 0;
      ev_seq = ($urandom % 4) == 0;
      ev_src = 31'($urandom);
      ev_dst = $urandom;
      bus_req = ($urandom % 2) == 0;
      bus_we = ($urandom % 2) == 0;
      bus_addr = AW'($urandom);
      bus_wdata = $urandom;
      step(1);
    end
    ev_valid = 0; bus_req = 0;
    step(4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      nerr++; nchk++;
      $display("FAIL watchdog R4 actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule